// File: doc/BRIEF.md
# Transceiver Power-State Sequencer

This block decides when the core of an infrared transceiver may run. It watches the active-low power-down pin, the active-low reset pin, the data/control select pin and three configuration bits: transmit enable, receive enable and oscillator keep-alive. From these it drives the oscillator enable, the core clock gate, the internal core reset and a ready flag. It also parks the serial data pin and the status pin in a programmed state while the core is stopped.

Power-down comes from one of two places. The hard path is the power-down pin held low. This stops the oscillator and ignores the reset pin, so configuration held elsewhere survives. The soft path is entered when both enables are clear while the select pin is high. In that case the keep-alive bit chooses between keeping the oscillator running, for a wake-up on the next clock, and stopping it to save power. Each time the oscillator restarts, a counter in system-clock units stands in for the crystal startup time. The core clock is withheld until the counter reaches its terminal count.

At the clock edge that releases the internal reset, the block records whether the oscillator was already stable. That recorded value selects whether the external clock pin is driven as an output.

Top module: `irx_power_seq`

## Requirements
- R1: While `pd_n` is sampled low, `osc_en` and `core_clk_en` are 0 after the next clock edge.
- R2: While `pd_n` is high and `reset_n` is low, `core_rst` is 1 after the next clock edge.
- R3: While `pd_n` is low, `reset_n` has no effect. `core_rst` is 0 after the next edge, and `ext_clk_drive` keeps its value.
- R4: The soft power-down condition is `tx_en`=0, `rx_en`=0 and `ctl_sel`=1. When it is sampled, `core_clk_en` is 0 after the next edge. If `ctl_sel` is 0, the core keeps running.
- R5: In soft power-down, `osc_keep`=1 keeps `osc_en` at 1. With `osc_keep`=0, `osc_en` is 0 after the next edge.
- R6: Count the first clock edge at which the oscillator is requested again after being off as edge 1. `osc_en` is 1 from edge 1. `core_clk_en` rises at edge WAKE_CYCLES+2 and not before.
- R7: If the oscillator was kept running during soft power-down, `core_ready` is 1 one clock edge after the soft condition is left.
- R8: While `core_clk_en` is 0, each parked pin follows its 2-bit code: 00 drives low, 01 drives high, and 10 or 11 floats (output enable 0). While `core_clk_en` is 1, the pin is enabled and carries the core's value.
- R9: `ext_clk_drive` takes the oscillator-stable state at the edge that releases `core_rst`. It is 0 while reset is applied and holds its value at all other times, including across power-down.
- R10: `core_ready` is 1 exactly when `core_clk_en` is 1 and `core_rst` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pd_n | input | 1 | Power-down pin, low stops everything |
| reset_n | input | 1 | Reset pin, active low, honoured only while `pd_n` is high |
| ctl_sel | input | 1 | Data/control select pin, high is part of the soft power-down condition |
| tx_en | input | 1 | Transmit section enable bit |
| rx_en | input | 1 | Receive section enable bit |
| osc_keep | input | 1 | Keep oscillator running during soft power-down |
| ser_park | input | 2 | Park code of the serial data pin |
| stat_park | input | 2 | Park code of the status pin |
| core_ser | input | 1 | Serial value driven by the core |
| core_stat | input | 1 | Status value driven by the core |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Core clock gate enable |
| core_rst | output | 1 | Internal core reset, active high |
| core_ready | output | 1 | Core is clocked and out of reset |
| ext_clk_drive | output | 1 | 1 drives the external clock pin as an output |
| ser_o | output | 1 | Serial pin output value |
| ser_oe | output | 1 | Serial pin output enable |
| stat_o | output | 1 | Status pin output value |
| stat_oe | output | 1 | Status pin output enable |

## Verification
The wake-up timing is swept one edge at a time after each of three restart causes: a cold start under reset, a soft power-down that stopped the oscillator, and a hard power-down. These sweeps separate an off-by-one in the startup counter from a gate that opens too early. The soft condition is tried with the keep-alive bit set and clear, and with the select pin low, which shows whether the oscillator decision and the gate decision are made apart. All sixteen park-code pairs are applied while stopped, and both core values are applied while running. Reset is released once with the oscillator stable and once while it is still starting, and reset is pulsed during hard power-down, so a wrong capture edge for the clock-pin direction becomes visible.

// File: rtl/irx_pwr_pkg.sv
package irx_pwr_pkg;

    typedef enum logic [1:0] {
        PARK_LOW    = 2'b00,
        PARK_HIGH   = 2'b01,
        PARK_FLOAT  = 2'b10,
        PARK_FLOAT2 = 2'b11
    } park_e;

    typedef struct packed {
        logic oe;
        logic val;
    } pin_drive_t;

    localparam int unsigned NPINS = 2;

    function automatic pin_drive_t park_drive(input logic [1:0] code);
        pin_drive_t d;
        case (park_e'(code))
            PARK_LOW:  d = '{oe: 1'b1, val: 1'b0};
            PARK_HIGH: d = '{oe: 1'b1, val: 1'b1};
            default:   d = '{oe: 1'b0, val: 1'b0};
        endcase
        return d;
    endfunction

    function automatic logic soft_idle(input logic tx, input logic rx, input logic sel);
        return !tx && !rx && sel;
    endfunction

endpackage

// File: rtl/irx_osc_timer.sv
module irx_osc_timer #(
    parameter int unsigned WAKE_CYCLES = 92160
) (
    input  logic clk,
    input  logic pd_n,
    input  logic want_osc,
    output logic osc_on,
    output logic osc_stable
);
    localparam int unsigned CNT_W = $clog2(WAKE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAKE_CYCLES);

    logic             osc_on_q;
    logic [CNT_W-1:0] cnt_q;
    logic             alive_q;

    always_ff @(posedge clk) begin
        osc_on_q <= want_osc;
        if (!pd_n || !osc_on_q)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
        alive_q <= 1'b1;
    end

    assign osc_on     = osc_on_q;
    assign osc_stable = osc_on_q && (cnt_q == LAST);

    // R6: the startup count never runs past its terminal value
    p_cnt_cap_r6: assert property (@(posedge clk) disable iff (!alive_q)
        cnt_q <= LAST);
    // R6: a count only advances while the oscillator runs
    p_cnt_moves_r6: assert property (@(posedge clk) disable iff (!alive_q)
        (cnt_q != $past(cnt_q) && cnt_q != '0) |-> $past(osc_on_q));

endmodule

// File: rtl/irx_rst_ctl.sv
module irx_rst_ctl (
    input  logic clk,
    input  logic pd_n,
    input  logic reset_n,
    input  logic osc_stable,
    output logic core_rst,
    output logic ext_clk_drive
);
    logic rst_req;
    logic core_rst_q;
    logic dir_q;
    logic alive_q;

    assign rst_req = pd_n && !reset_n;

    always_ff @(posedge clk) begin
        core_rst_q <= rst_req;
        if (rst_req)
            dir_q <= 1'b0;
        else if (core_rst_q)
            dir_q <= osc_stable;
        alive_q <= 1'b1;
    end

    assign core_rst      = core_rst_q;
    assign ext_clk_drive = dir_q;

    // R2: reset applies while the power-down pin is high
    p_rst_apply_r2: assert property (@(posedge clk) disable iff (!alive_q)
        (pd_n && !reset_n) |=> core_rst);
    // R3: reset pin ignored during hard power-down
    p_rst_ignored_r3: assert property (@(posedge clk) disable iff (!alive_q)
        !pd_n |=> !core_rst);
    // R9: direction only moves on the releasing edge or under reset
    p_dir_hold_r9: assert property (@(posedge clk) disable iff (!alive_q)
        (!core_rst && !rst_req) |=> $stable(ext_clk_drive));

endmodule

// File: rtl/irx_pin_park.sv
module irx_pin_park
    import irx_pwr_pkg::*;
(
    input  logic       run,
    input  logic [1:0] code,
    input  logic       core_val,
    output logic       pin_o,
    output logic       pin_oe
);
    pin_drive_t parked;

    always_comb begin
        parked = park_drive(code);
        if (run) begin
            pin_o  = core_val;
            pin_oe = 1'b1;
        end else begin
            pin_o  = parked.val;
            pin_oe = parked.oe;
        end
    end

    // R8: float codes release the pin whenever the core is stopped
    always_comb begin
        if (!run && code[1])
            p_float_r8: assert (!pin_oe);
    end

endmodule

// File: rtl/irx_power_seq.sv
module irx_power_seq
    import irx_pwr_pkg::*;
#(
    parameter int unsigned WAKE_CYCLES = 92160
) (
    input  logic       clk,
    input  logic       pd_n,
    input  logic       reset_n,
    input  logic       ctl_sel,
    input  logic       tx_en,
    input  logic       rx_en,
    input  logic       osc_keep,
    input  logic [1:0] ser_park,
    input  logic [1:0] stat_park,
    input  logic       core_ser,
    input  logic       core_stat,
    output logic       osc_en,
    output logic       core_clk_en,
    output logic       core_rst,
    output logic       core_ready,
    output logic       ext_clk_drive,
    output logic       ser_o,
    output logic       ser_oe,
    output logic       stat_o,
    output logic       stat_oe
);
    logic soft_pd;
    logic want_osc;
    logic osc_on;
    logic osc_stable;
    logic gate_q;
    logic alive_q;

    logic [NPINS-1:0][1:0] pin_code;
    logic [NPINS-1:0]      pin_core;
    logic [NPINS-1:0]      pin_val;
    logic [NPINS-1:0]      pin_en;

    assign soft_pd  = soft_idle(tx_en, rx_en, ctl_sel);
    assign want_osc = pd_n && !(soft_pd && !osc_keep);

    irx_osc_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_timer (
        .clk        (clk),
        .pd_n       (pd_n),
        .want_osc   (want_osc),
        .osc_on     (osc_on),
        .osc_stable (osc_stable)
    );

    irx_rst_ctl u_rst (
        .clk           (clk),
        .pd_n          (pd_n),
        .reset_n       (reset_n),
        .osc_stable    (osc_stable),
        .core_rst      (core_rst),
        .ext_clk_drive (ext_clk_drive)
    );

    always_ff @(posedge clk) begin
        gate_q  <= osc_stable && pd_n && !soft_pd;
        alive_q <= 1'b1;
    end

    assign osc_en      = osc_on;
    assign core_clk_en = gate_q;
    assign core_ready  = gate_q && !core_rst;

    assign pin_code = {stat_park, ser_park};
    assign pin_core = {core_stat, core_ser};

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        irx_pin_park u_park (
            .run      (gate_q),
            .code     (pin_code[i]),
            .core_val (pin_core[i]),
            .pin_o    (pin_val[i]),
            .pin_oe   (pin_en[i])
        );
    end

    assign ser_o   = pin_val[0];
    assign ser_oe  = pin_en[0];
    assign stat_o  = pin_val[1];
    assign stat_oe = pin_en[1];

    // R1: hard power-down stops oscillator and clock gate
    p_hard_stop_r1: assert property (@(posedge clk) disable iff (!alive_q)
        !pd_n |=> (!osc_en && !core_clk_en));
    // R4: soft power-down closes the gate
    p_soft_gate_r4: assert property (@(posedge clk) disable iff (!alive_q)
        soft_pd |=> !core_clk_en);
    // R5: keep-alive holds a running oscillator
    p_keep_osc_r5: assert property (@(posedge clk) disable iff (!alive_q)
        (pd_n && soft_pd && osc_keep && osc_en) |=> osc_en);
    // R5: without keep-alive the oscillator stops
    p_drop_osc_r5: assert property (@(posedge clk) disable iff (!alive_q)
        (soft_pd && !osc_keep) |=> !osc_en);
    // R6: the gate never opens on an unstable oscillator
    p_gate_stable_r6: assert property (@(posedge clk) disable iff (!alive_q)
        $rose(core_clk_en) |-> $past(osc_stable));
    // R7: kept oscillator gives a one-clock wake
    p_quick_wake_r7: assert property (@(posedge clk) disable iff (!alive_q)
        (pd_n && !soft_pd && osc_en && $past(osc_en) && $past(pd_n) && core_clk_en == 1'b0
         && $past(core_clk_en) == 1'b0 && osc_keep && $past(soft_pd)) |=> core_clk_en || !$past(osc_en, 1) || !osc_en);
    // R10: ready never overlaps reset
    p_ready_r10: assert property (@(posedge clk) disable iff (!alive_q)
        core_ready |-> (!core_rst && core_clk_en));

endmodule

// File: tb/sim_irx_power_seq.sv
`timescale 1ns/1ps
module sim_irx_power_seq;
    localparam int unsigned WAKE = 5;

    logic clk = 1'b0;
    logic pd_n, reset_n, ctl_sel, tx_en, rx_en, osc_keep;
    logic [1:0] ser_park, stat_park;
    logic core_ser, core_stat;
    logic osc_en, core_clk_en, core_rst, core_ready, ext_clk_drive;
    logic ser_o, ser_oe, stat_o, stat_oe;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irx_power_seq #(.WAKE_CYCLES(WAKE)) u0 (
        .clk(clk), .pd_n(pd_n), .reset_n(reset_n), .ctl_sel(ctl_sel),
        .tx_en(tx_en), .rx_en(rx_en), .osc_keep(osc_keep),
        .ser_park(ser_park), .stat_park(stat_park),
        .core_ser(core_ser), .core_stat(core_stat),
        .osc_en(osc_en), .core_clk_en(core_clk_en), .core_rst(core_rst),
        .core_ready(core_ready), .ext_clk_drive(ext_clk_drive),
        .ser_o(ser_o), .ser_oe(ser_oe), .stat_o(stat_o), .stat_oe(stat_oe)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wake_sweep(input string req, input bit in_reset);
        for (int n = 1; n <= int'(WAKE) + 3; n++) begin
            step(1);
            chk($sformatf("%s osc_en n=%0d", req, n), osc_en, 1);
            chk($sformatf("%s core_clk_en n=%0d", req, n), core_clk_en, (n >= int'(WAKE) + 2) ? 1 : 0);
            chk($sformatf("R10 core_ready n=%0d", n), core_ready,
                (!in_reset && n >= int'(WAKE) + 2) ? 1 : 0);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        pd_n = 0; reset_n = 0; ctl_sel = 0; tx_en = 1; rx_en = 1; osc_keep = 0;
        ser_park = 2'b00; stat_park = 2'b01; core_ser = 1; core_stat = 0;
        step(2);
        // reset state under hard power-down
        chk("R1 osc_en off", osc_en, 0);
        chk("R1 gate off", core_clk_en, 0);
        chk("R3 reset ignored", core_rst, 0);
        chk("R8 ser parked low oe", ser_oe, 1);
        chk("R8 ser parked low val", ser_o, 0);
        chk("R8 stat parked high val", stat_o, 1);

        // cold start under reset
        pd_n = 1;
        wake_sweep("R6 cold", 1'b1);
        chk("R2 reset applied", core_rst, 1);
        reset_n = 1;
        step(1);
        chk("R2 reset released", core_rst, 0);
        chk("R9 dir captured stable", ext_clk_drive, 1);
        chk("R10 ready after release", core_ready, 1);

        // running pins follow the core
        for (int v = 0; v < 2; v++) begin
            core_ser = v[0]; core_stat = ~v[0];
            #1;
            chk("R8 run ser oe", ser_oe, 1);
            chk("R8 run ser val", ser_o, v);
            chk("R8 run stat oe", stat_oe, 1);
            chk("R8 run stat val", stat_o, 1 - v);
        end

        // select low: not a soft power-down
        tx_en = 0; rx_en = 0; ctl_sel = 0;
        step(2);
        chk("R4 select low keeps gate", core_clk_en, 1);

        // soft power-down with oscillator kept
        ctl_sel = 1; osc_keep = 1;
        step(1);
        chk("R4 soft gate off", core_clk_en, 0);
        chk("R5 keep osc on", osc_en, 1);
        chk("R8 soft parked ser val", ser_o, 0);
        step(3);
        chk("R5 keep osc still on", osc_en, 1);
        tx_en = 1;
        step(1);
        chk("R7 quick wake ready", core_ready, 1);

        // soft power-down with oscillator stopped
        tx_en = 0; osc_keep = 0;
        step(1);
        chk("R5 drop osc", osc_en, 0);
        chk("R4 soft gate off 2", core_clk_en, 0);
        step(2);
        rx_en = 1;
        wake_sweep("R6 soft", 1'b0);

        // hard power-down with reset pulse ignored
        pd_n = 0;
        step(1);
        chk("R1 hard osc off", osc_en, 0);
        chk("R1 hard gate off", core_clk_en, 0);
        reset_n = 0;
        step(2);
        chk("R3 no reset in power-down", core_rst, 0);
        chk("R3 dir kept in power-down", ext_clk_drive, 1);
        for (int s = 0; s < 4; s++) begin
            for (int t = 0; t < 4; t++) begin
                ser_park = s[1:0]; stat_park = t[1:0];
                #1;
                chk($sformatf("R8 ser oe code=%0d", s), ser_oe, (s < 2) ? 1 : 0);
                if (s < 2) chk($sformatf("R8 ser val code=%0d", s), ser_o, (s == 1) ? 1 : 0);
                chk($sformatf("R8 stat oe code=%0d", t), stat_oe, (t < 2) ? 1 : 0);
                if (t < 2) chk($sformatf("R8 stat val code=%0d", t), stat_o, (t == 1) ? 1 : 0);
            end
        end
        reset_n = 1; pd_n = 1;
        wake_sweep("R6 hard", 1'b0);
        chk("R9 dir kept after power-down", ext_clk_drive, 1);

        // reset released before the oscillator is stable
        pd_n = 0;
        step(2);
        pd_n = 1; reset_n = 0;
        step(1);
        chk("R2 reset during startup", core_rst, 1);
        chk("R9 dir cleared in reset", ext_clk_drive, 0);
        reset_n = 1;
        step(1);
        chk("R9 dir captured unstable", ext_clk_drive, 0);
        step(int'(WAKE) + 3);
        chk("R9 dir held", ext_clk_drive, 0);
        chk("R10 ready late", core_ready, 1);

        finish_run();
    end
endmodule